// File: doc/BRIEF.md
# Dual Register Readiness Scoreboard

This block records, for every physical register of an out-of-order core, whether its value can be consumed. It keeps two independent readiness vectors. The early vector is marked when a producing pipeline announces a wakeup, which may happen before the result exists. Rename consults it so that dependents can be scheduled ahead of the data. The safe vector is marked only when the result is actually written into the register file. The register-read stage consults it before it reads operands.

When rename allocates a fresh physical register as a destination, that register becomes not-ready in both vectors. Every producing pipeline is expected to drive both its wakeup port and its write port. The block keeps the two vectors strictly apart. Every lookup is combinational. A set arriving in the same cycle forwards to a lookup of the same register. A clear takes effect only from the following cycle.

Top module: `sbTop`

## Requirements
- R1: After reset, all 64 physical registers read as ready on every rename lookup port and every read-stage lookup port.
- R2: A valid allocation of register `p` clears `p` in both vectors from the next cycle on. A lookup of `p` in the allocation cycle still returns the previous state.
- R3: A valid wakeup of register `p` sets `p` in the early vector, and rename lookups of `p` return ready from the next cycle on.
- R4: A valid write of register `p` sets `p` in the safe vector, and read-stage lookups of `p` return ready from the next cycle on.
- R5: A rename lookup of `p` returns ready in the same cycle as a wakeup of `p`, on any wakeup port.
- R6: A read-stage lookup of `p` returns ready in the same cycle as a write of `p`, on any write port.
- R7: A wakeup never changes the safe vector, and a write never changes the early vector. After a wakeup of a not-ready register alone, read-stage lookups of it stay not-ready, and the reverse also holds.
- R8: When an allocation and a set target the same register in the same cycle, the register is not-ready in the affected vector from the next cycle.
- R9: All 2 allocation, 3 wakeup, 3 write, 2 rename lookup and 3 read-stage lookup ports act independently and at the same time. Lookup port k returns the readiness of the register on its own index input.
- R10: A register that is not allocated, woken or written in a cycle keeps its readiness in both vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 2 | Allocation strobe per rename slot |
| allocIdx | input | 2x6 | Allocated physical register per slot |
| wakeValid | input | 3 | Early wakeup strobe per producer |
| wakeIdx | input | 3x6 | Register announced by each wakeup |
| writeValid | input | 3 | Register-file write strobe per producer |
| writeIdx | input | 3x6 | Register written by each producer |
| renIdx | input | 2x6 | Register looked up by each rename port |
| renReady | output | 2 | Early-vector readiness per rename port |
| rdIdx | input | 3x6 | Register looked up by each read-stage port |
| rdReady | output | 3 | Safe-vector readiness per read-stage port |

## Verification
The bench goes after same-cycle collisions. A lookup that meets a set of its register must return ready, or dependents stall for one needless cycle. A lookup that meets an allocation must see the old state, or the clear leaks forward. An allocation and a set of the same register in one cycle must leave it cleared, or a stale wakeup marks a fresh destination ready and a consumer reads garbage. It also checks that a wakeup alone never makes the safe vector ready, since a design that merges the two would let register read run ahead of the data. A long random phase over a narrow index range packs many port collisions into each cycle.

// File: rtl/sbPkg.sv
package sbPkg;
  localparam int PREGS = 64;
  localparam int IDXW  = $clog2(PREGS);

  typedef logic [PREGS-1:0] regMaskT;

  // strobes from control to datapath, one bit per physical register
  typedef struct packed {
    regMaskT aggrSet;
    regMaskT consSet;
    regMaskT clr;
  } sbStrobeT;
endpackage

// File: rtl/sbCtrl.sv
module sbCtrl #(
  parameter int AllocPorts = 2,
  parameter int WakePorts  = 3,
  parameter int WritePorts = 3,
  localparam int IdxW = sbPkg::IDXW
) (
  input  logic [AllocPorts-1:0]           allocValid,
  input  logic [AllocPorts-1:0][IdxW-1:0] allocIdx,
  input  logic [WakePorts-1:0]            wakeValid,
  input  logic [WakePorts-1:0][IdxW-1:0]  wakeIdx,
  input  logic [WritePorts-1:0]           writeValid,
  input  logic [WritePorts-1:0][IdxW-1:0] writeIdx,
  output sbPkg::sbStrobeT                 strobes
);
  always_comb begin
    strobes = '0;
    for (int i = 0; i < AllocPorts; i++)
      if (allocValid[i]) strobes.clr[allocIdx[i]] = 1'b1;
    for (int i = 0; i < WakePorts; i++)
      if (wakeValid[i]) strobes.aggrSet[wakeIdx[i]] = 1'b1;
    for (int i = 0; i < WritePorts; i++)
      if (writeValid[i]) strobes.consSet[writeIdx[i]] = 1'b1;
  end
endmodule

// File: rtl/sbDatapath.sv
module sbDatapath #(
  parameter int RenPorts  = 2,
  parameter int ReadPorts = 3,
  localparam int IdxW = sbPkg::IDXW
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  sbPkg::sbStrobeT                strobes,
  input  logic [RenPorts-1:0][IdxW-1:0]  renIdx,
  output logic [RenPorts-1:0]            renReady,
  input  logic [ReadPorts-1:0][IdxW-1:0] rdIdx,
  output logic [ReadPorts-1:0]           rdReady,
  output sbPkg::regMaskT                 aggrVec,
  output sbPkg::regMaskT                 consVec
);
  sbPkg::regMaskT aggrQ, consQ;

  // clear wins over a set of the same register in one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aggrQ <= '1;
      consQ <= '1;
    end else begin
      aggrQ <= (aggrQ | strobes.aggrSet) & ~strobes.clr;
      consQ <= (consQ | strobes.consSet) & ~strobes.clr;
    end
  end

  for (genvar g = 0; g < RenPorts; g++) begin : genRen
    assign renReady[g] = aggrQ[renIdx[g]] | strobes.aggrSet[renIdx[g]];
  end

  for (genvar g = 0; g < ReadPorts; g++) begin : genRd
    assign rdReady[g] = consQ[rdIdx[g]] | strobes.consSet[rdIdx[g]];
  end

  assign aggrVec = aggrQ;
  assign consVec = consQ;
endmodule

// File: rtl/sbTop.sv
module sbTop #(
  parameter int AllocPorts = 2,
  parameter int WakePorts  = 3,
  parameter int WritePorts = 3,
  parameter int RenPorts   = 2,
  parameter int ReadPorts  = 3,
  localparam int IdxW = sbPkg::IDXW
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [AllocPorts-1:0]           allocValid,
  input  logic [AllocPorts-1:0][IdxW-1:0] allocIdx,
  input  logic [WakePorts-1:0]            wakeValid,
  input  logic [WakePorts-1:0][IdxW-1:0]  wakeIdx,
  input  logic [WritePorts-1:0]           writeValid,
  input  logic [WritePorts-1:0][IdxW-1:0] writeIdx,
  input  logic [RenPorts-1:0][IdxW-1:0]   renIdx,
  output logic [RenPorts-1:0]             renReady,
  input  logic [ReadPorts-1:0][IdxW-1:0]  rdIdx,
  output logic [ReadPorts-1:0]            rdReady
);
  sbPkg::sbStrobeT strobes;
  sbPkg::regMaskT  aggrVec, consVec;

  sbCtrl #(
    .AllocPorts(AllocPorts), .WakePorts(WakePorts), .WritePorts(WritePorts)
  ) i_ctrl (
    .allocValid(allocValid), .allocIdx(allocIdx),
    .wakeValid(wakeValid),   .wakeIdx(wakeIdx),
    .writeValid(writeValid), .writeIdx(writeIdx),
    .strobes(strobes)
  );

  sbDatapath #(.RenPorts(RenPorts), .ReadPorts(ReadPorts)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .renIdx(renIdx), .renReady(renReady),
    .rdIdx(rdIdx),   .rdReady(rdReady),
    .aggrVec(aggrVec), .consVec(consVec)
  );
endmodule

// File: rtl/sbChecker.sv
module sbChecker #(
  parameter int AllocPorts = 2,
  parameter int WakePorts  = 3,
  parameter int WritePorts = 3,
  parameter int RenPorts   = 2,
  parameter int ReadPorts  = 3,
  localparam int IdxW = sbPkg::IDXW
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [AllocPorts-1:0]           allocValid,
  input logic [AllocPorts-1:0][IdxW-1:0] allocIdx,
  input logic [WakePorts-1:0]            wakeValid,
  input logic [WakePorts-1:0][IdxW-1:0]  wakeIdx,
  input logic [WritePorts-1:0]           writeValid,
  input logic [WritePorts-1:0][IdxW-1:0] writeIdx,
  input logic [RenPorts-1:0][IdxW-1:0]   renIdx,
  input logic [RenPorts-1:0]             renReady,
  input sbPkg::regMaskT                  aggrVec,
  input sbPkg::regMaskT                  consVec
);
  function automatic logic allocHits(input logic [IdxW-1:0] idx);
    logic hit = 1'b0;
    for (int i = 0; i < AllocPorts; i++)
      if (allocValid[i] && allocIdx[i] == idx) hit = 1'b1;
    return hit;
  endfunction

  // R1
  a_r1_reset_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&aggrVec && &consVec));

  for (genvar g = 0; g < AllocPorts; g++) begin : genAlloc
    // R2 and R8
    a_r2_alloc_clears: assert property (@(posedge clk) disable iff (!rstN)
      allocValid[g] |=> (!aggrVec[$past(allocIdx[g])] && !consVec[$past(allocIdx[g])]));
  end

  for (genvar g = 0; g < WakePorts; g++) begin : genWake
    // R3
    a_r3_wake_sets: assert property (@(posedge clk) disable iff (!rstN)
      (wakeValid[g] && !allocHits(wakeIdx[g])) |=> aggrVec[$past(wakeIdx[g])]);
    // R5
    a_r5_wake_bypass: assert property (@(posedge clk) disable iff (!rstN)
      (wakeValid[g] && wakeIdx[g] == renIdx[0]) |-> renReady[0]);
  end

  for (genvar g = 0; g < WritePorts; g++) begin : genWrite
    // R4
    a_r4_write_sets: assert property (@(posedge clk) disable iff (!rstN)
      (writeValid[g] && !allocHits(writeIdx[g])) |=> consVec[$past(writeIdx[g])]);
  end

  // R7 and R10
  a_r7_cons_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (!(|writeValid) && !(|allocValid)) |=> $stable(consVec));
  a_r7_aggr_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (!(|wakeValid) && !(|allocValid)) |=> $stable(aggrVec));
endmodule

bind sbTop sbChecker #(
  .AllocPorts(AllocPorts), .WakePorts(WakePorts), .WritePorts(WritePorts),
  .RenPorts(RenPorts), .ReadPorts(ReadPorts)
) i_sbChecker (
  .clk(clk), .rstN(rstN),
  .allocValid(allocValid), .allocIdx(allocIdx),
  .wakeValid(wakeValid), .wakeIdx(wakeIdx),
  .writeValid(writeValid), .writeIdx(writeIdx),
  .renIdx(renIdx), .renReady(renReady),
  .aggrVec(aggrVec), .consVec(consVec)
);

// File: tb/test_sbTop.sv
`timescale 1ns/1ps
module test_sbTop;
  localparam int NA = 2, NW = 3, NC = 3, NR = 2, ND = 3, IW = 6, NREG = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NA-1:0] allocValid = '0;
  logic [NA-1:0][IW-1:0] allocIdx = '0;
  logic [NW-1:0] wakeValid = '0;
  logic [NW-1:0][IW-1:0] wakeIdx = '0;
  logic [NC-1:0] writeValid = '0;
  logic [NC-1:0][IW-1:0] writeIdx = '0;
  logic [NR-1:0][IW-1:0] renIdx = '0;
  logic [NR-1:0] renReady;
  logic [ND-1:0][IW-1:0] rdIdx = '0;
  logic [ND-1:0] rdReady;

  int checks = 0;
  int fails = 0;

  // reference state
  bit earlyRdy[NREG];
  bit safeRdy[NREG];

  always #4 clk = ~clk;

  sbTop i_sbTop (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocIdx(allocIdx),
    .wakeValid(wakeValid), .wakeIdx(wakeIdx),
    .writeValid(writeValid), .writeIdx(writeIdx),
    .renIdx(renIdx), .renReady(renReady),
    .rdIdx(rdIdx), .rdReady(rdReady)
  );

  function automatic bit wokenNow(int r);
    for (int i = 0; i < NW; i++) if (wakeValid[i] && wakeIdx[i] == r) return 1;
    return 0;
  endfunction
  function automatic bit writtenNow(int r);
    for (int i = 0; i < NC; i++) if (writeValid[i] && writeIdx[i] == r) return 1;
    return 0;
  endfunction

  task automatic compareOutputs(string tag);
    for (int k = 0; k < NR; k++) begin
      bit exp = earlyRdy[renIdx[k]] | wokenNow(renIdx[k]);
      checks++;
      if (renReady[k] !== exp) begin
        fails++;
        $display("FAIL %s renReady[%0d] reg %0d actual %b expected %b", tag, k, renIdx[k], renReady[k], exp);
      end
    end
    for (int k = 0; k < ND; k++) begin
      bit exp = safeRdy[rdIdx[k]] | writtenNow(rdIdx[k]);
      checks++;
      if (rdReady[k] !== exp) begin
        fails++;
        $display("FAIL %s rdReady[%0d] reg %0d actual %b expected %b", tag, k, rdIdx[k], rdReady[k], exp);
      end
    end
  endtask

  task automatic updateModel();
    bit nextE[NREG];
    bit nextS[NREG];
    for (int r = 0; r < NREG; r++) begin
      nextE[r] = earlyRdy[r] | wokenNow(r);
      nextS[r] = safeRdy[r] | writtenNow(r);
    end
    for (int i = 0; i < NA; i++)
      if (allocValid[i]) begin
        nextE[allocIdx[i]] = 0;
        nextS[allocIdx[i]] = 0;
      end
    earlyRdy = nextE;
    safeRdy = nextS;
  endtask

  // inputs are set just after a falling edge; compare, then advance a cycle
  task automatic step(string tag);
    #1;
    compareOutputs(tag);
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  task automatic idleIn();
    allocValid = '0; wakeValid = '0; writeValid = '0;
  endtask

  task automatic lookAt(int a, int b, int c, int d, int e);
    renIdx[0] = a[IW-1:0]; renIdx[1] = b[IW-1:0];
    rdIdx[0] = c[IW-1:0]; rdIdx[1] = d[IW-1:0]; rdIdx[2] = e[IW-1:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin earlyRdy[r] = 1; safeRdy[r] = 1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: everything ready after reset
    lookAt(0, 63, 0, 31, 63); step("R1");
    lookAt(17, 42, 5, 9, 12); step("R1");

    // R2: clear not visible in allocation cycle, visible next
    allocValid = 2'b11; allocIdx[0] = 6'd5; allocIdx[1] = 6'd9;
    lookAt(5, 9, 5, 9, 0); step("R2 same-cycle");
    idleIn(); lookAt(5, 9, 5, 9, 1); step("R2 next-cycle");

    // R3 then R7: wakeup touches only the early vector
    wakeValid = 3'b010; wakeIdx[1] = 6'd5;
    lookAt(9, 9, 5, 9, 9); step("R3 wake cycle");
    idleIn(); lookAt(5, 9, 5, 5, 9); step("R3 R7 after wake");

    // R4, R6: write on port 2 bypasses to read lookups; R7 early stays clear
    writeValid = 3'b100; writeIdx[2] = 6'd9;
    lookAt(9, 5, 9, 9, 5); step("R6 write bypass");
    idleIn(); lookAt(9, 5, 9, 5, 9); step("R4 R7 after write");

    // R5: wakeup on port 2 bypasses to rename lookup of a cleared reg
    allocValid = 2'b01; allocIdx[0] = 6'd7; step("R2 alloc 7");
    idleIn(); wakeValid = 3'b100; wakeIdx[2] = 6'd7;
    lookAt(7, 7, 7, 7, 7); step("R5 wake bypass");
    idleIn(); lookAt(7, 7, 7, 7, 7); step("R5 R7 after");

    // R8: allocation collides with wakeup and write of the same register
    allocValid = 2'b10; allocIdx[1] = 6'd12;
    wakeValid = 3'b001; wakeIdx[0] = 6'd12;
    writeValid = 3'b001; writeIdx[0] = 6'd12;
    lookAt(12, 12, 12, 12, 12); step("R8 collide");
    idleIn(); step("R8 cleared");

    // R10: idle cycles hold state
    repeat (3) begin lookAt(5, 7, 9, 12, 63); step("R10 hold"); end

    // R9: random traffic over a narrow range to force collisions
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NA; i++) begin
        allocValid[i] = ($urandom % 4) == 0; allocIdx[i] = IW'($urandom % 16);
      end
      for (int i = 0; i < NW; i++) begin
        wakeValid[i] = ($urandom % 3) == 0; wakeIdx[i] = IW'($urandom % 16);
      end
      for (int i = 0; i < NC; i++) begin
        writeValid[i] = ($urandom % 3) == 0; writeIdx[i] = IW'($urandom % 16);
      end
      for (int k = 0; k < NR; k++) renIdx[k] = IW'($urandom % 16);
      for (int k = 0; k < ND; k++) rdIdx[k] = IW'($urandom % 16);
      step("R9 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule